// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block tracks the event and interrupt state of a processor core across sixteen priority levels. A lower level index means a higher priority. Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt, 3 is the exception level and 5 is the hardware-error level. Level 6 is the timer and levels 7 to 15 are general purpose. Position 4 is not a real event. It holds a global-disable flag inside the pending word.

Each request is latched. On every cycle the latched requests are arbitrated combinationally against the mask, the global-disable flag, the current level and the self-nesting enable. At most one level is accepted per clock edge, and the accepted level is reported on a one-cycle strobe. A return request names a level and carries bit 0 of the saved return address. If the return is legal, it clears that pending level. An illegal return only raises a flag. Software reaches five 32-bit word registers through a simple register port.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the mask register reads 0x1F, the pending register reads 0x12 (bit 1 reset level, bit 4 global disable), and the latched, override and priority registers read 0. The current level is 1 and supervisor mode is high.
- R2: The registers sit at byte addresses 0x00 (override, all 32 bits kept), 0x04 (mask), 0x08 (pending), 0x0C (latched) and 0x10 (priority). A mask write changes only bits 5–15, and bits 0–4 stay 1. A priority write keeps only bits 0–4. Writes to the pending register are ignored. Any other address reads 0.
- R3: A request input sets its latched bit, except input 4, which is ignored. A write to 0x0C clears each latched bit written as 1. A request for the same level in the same cycle wins over the clear.
- R4: The current level (cur_lvl) is the lowest set pending bit, with bits 0 and 4 excluded. It is 16 (user mode) when no such bit is set. supervisor is high exactly when cur_lvl is not 16.
- R5: Latched levels 0 and 1 are always accepted.
- R6: A latched level 2 or 3 is accepted only when its index is below cur_lvl. A new request at level 2 or 3 with cur_lvl at or below that level raises dbl_fault for one cycle on the next edge. That request stays latched.
- R7: A level of 5 or above is blocked in three cases: its mask bit is clear, the global-disable bit is set outside user mode, or its index is not below cur_lvl. An equal index is accepted only while nest_en is high.
- R8: The lowest-index eligible level wins, and only one is accepted per edge. On the edge after acceptance, acc_valid pulses with acc_lvl. That level's pending bit is set and its latched bit is cleared.
- R9: Accepting a level of 5 or above sets the global-disable bit. vec_sel pulses with acc_valid when the level is 7 or above and its override bit is set. acc_self pulses when the accepted level equals cur_lvl.
- R10: A return is illegal in these cases, and each pulses illegal_op on the next edge with no state change:
  - a level-0 return while pending bit 0 is clear;
  - any other return in user mode;
  - a level-2 or level-3 return when cur_lvl is a different level;
  - a level-4 return;
  - a level-1 or level 5–15 return while cur_lvl is 2 or 3.
- R11: A legal return clears the pending bit of its level unless ret_addr_lsb is 1. A legal return at level 1 or at level 5 or above also clears the global-disable bit.
- R12: No level is accepted in a cycle with ret_req high. Requests that are latched but blocked are accepted without being requested again once a mask write, a return or a cleared global disable makes them eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| evt_req | input | 16 | Event request per level |
| nest_en | input | 1 | Self-nesting enable |
| ret_req | input | 1 | Return-from-event request |
| ret_lvl | input | 4 | Level being returned from |
| ret_addr_lsb | input | 1 | Bit 0 of the saved return address |
| cur_lvl | output | 5 | Current level, 16 for user mode |
| super_mode | output | 1 | Supervisor mode |
| acc_valid | output | 1 | Acceptance strobe |
| acc_lvl | output | 4 | Accepted level |
| acc_self | output | 1 | Accepted at the current level |
| vec_sel | output | 1 | Override vector selected |
| illegal_op | output | 1 | Illegal return strobe |
| dbl_fault | output | 1 | Double-fault strobe |

## Verification
The bench targets these corner cases:
- A request that arrives while the global disable is set must wait in the latch. It must be taken without a new request once a return clears the flag. A design that re-arbitrates only on new requests would leave it stuck.
- A write-one-to-clear in the same cycle as a request for the same level must leave the bit set. Getting this wrong drops a live request.
- Equal-level nesting must be gated by nest_en.
- Level 2 and level 3 requests at or below the current level must raise a double fault rather than being accepted.
- Returns that do not match the current level must flag as illegal and leave the pending word untouched. A design that clears the bit anyway would silently unwind the wrong handler.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NLVL = 16;
  localparam int LW = 5;
  localparam logic [LW-1:0] USER_LVL = LW'(NLVL);
  localparam int L_GDIS = 4;
  localparam int L_FIRST_MASKABLE = 5;
  localparam int L_FIRST_GP = 7;
  localparam logic [NLVL-1:0] FIXED_BITS = NLVL'(32'h1F);
  localparam logic [NLVL-1:0] LEVEL_SKIP = NLVL'(32'h11);

  localparam logic [4:0] A_OVR  = 5'h00;
  localparam logic [4:0] A_MASK = 5'h04;
  localparam logic [4:0] A_PEND = 5'h08;
  localparam logic [4:0] A_LAT  = 5'h0C;
  localparam logic [4:0] A_PRIO = 5'h10;

  // lowest set bit index, USER_LVL when empty
  function automatic logic [LW-1:0] first_set(input logic [NLVL-1:0] v);
    first_set = USER_LVL;
    for (int i = NLVL - 1; i >= 0; i--)
      if (v[i]) first_set = LW'(i);
  endfunction

  function automatic logic [LW-1:0] level_of(input logic [NLVL-1:0] pend);
    return first_set(pend & ~LEVEL_SKIP);
  endfunction
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
(
  input  logic [NLVL-1:0] cand,
  input  logic [NLVL-1:0] mask,
  input  logic            gdis,
  input  logic [LW-1:0]   cur,
  input  logic            nest_en,
  output logic            win_ok,
  output logic [LW-1:0]   win_lvl
);
  logic [NLVL-1:0] elig;
  logic            gdis_block;

  assign gdis_block = gdis && (cur != USER_LVL);

  for (genvar g = 0; g < NLVL; g++) begin : g_elig
    if (g < 2) begin : g_always
      assign elig[g] = cand[g];
    end else if (g < L_GDIS) begin : g_fault
      assign elig[g] = cand[g] && (LW'(g) < cur);
    end else if (g == L_GDIS) begin : g_none
      assign elig[g] = 1'b0;
    end else begin : g_mask
      assign elig[g] = cand[g] && mask[g] && !gdis_block &&
                       ((LW'(g) < cur) || (nest_en && (LW'(g) == cur)));
    end
  end

  assign win_lvl = first_set(elig);
  assign win_ok  = (win_lvl != USER_LVL);
endmodule

// File: rtl/evt_ret_check.sv
module evt_ret_check
  import evt_pkg::*;
(
  input  logic [3:0]      ret_lvl,
  input  logic            emu_pend,
  input  logic [LW-1:0]   cur,
  output logic            legal
);
  always_comb begin
    if (ret_lvl == 4'd0)
      legal = emu_pend;
    else if (cur == USER_LVL)
      legal = 1'b0;
    else if (ret_lvl == 4'd2 || ret_lvl == 4'd3)
      legal = (cur == {1'b0, ret_lvl});
    else if (ret_lvl == 4'(L_GDIS))
      legal = 1'b0;
    else
      legal = (cur != LW'(2)) && (cur != LW'(3));
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [4:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [15:0]   evt_req,
  input  logic          nest_en,
  input  logic          ret_req,
  input  logic [3:0]    ret_lvl,
  input  logic          ret_addr_lsb,
  output logic [4:0]    cur_lvl,
  output logic          super_mode,
  output logic          acc_valid,
  output logic [3:0]    acc_lvl,
  output logic          acc_self,
  output logic          vec_sel,
  output logic          illegal_op,
  output logic          dbl_fault
);
  logic [DW-1:0]   ovr;
  logic [NLVL-1:0] mask, pend, lat, prio;
  logic [NLVL-1:0] pend_n, lat_n, req_eff, cand;

  // named internal events
  logic            wr_ovr, wr_mask, wr_lat, wr_prio;
  logic            win_ok, acc_fire, ret_legal, ret_ok, ret_bad, df_hit;
  logic [LW-1:0]   win_lvl;
  logic [3:0]      acc_idx;

  assign wr_ovr  = bus_wr && (bus_addr == A_OVR);
  assign wr_mask = bus_wr && (bus_addr == A_MASK);
  assign wr_lat  = bus_wr && (bus_addr == A_LAT);
  assign wr_prio = bus_wr && (bus_addr == A_PRIO);

  assign req_eff    = evt_req & ~(NLVL'(1) << L_GDIS);
  assign cand       = lat | req_eff;
  assign cur_lvl    = level_of(pend);
  assign super_mode = |(pend & ~LEVEL_SKIP);

  evt_arbiter u_arb (
    .cand    (cand),
    .mask    (mask),
    .gdis    (pend[L_GDIS]),
    .cur     (cur_lvl),
    .nest_en (nest_en),
    .win_ok  (win_ok),
    .win_lvl (win_lvl)
  );

  evt_ret_check u_ret (
    .ret_lvl  (ret_lvl),
    .emu_pend (pend[0]),
    .cur      (cur_lvl),
    .legal    (ret_legal)
  );

  assign acc_fire = win_ok && !ret_req;
  assign acc_idx  = win_lvl[3:0];
  assign ret_ok   = ret_req && ret_legal;
  assign ret_bad  = ret_req && !ret_legal;
  assign df_hit   = (req_eff[2] && (cur_lvl <= LW'(2))) ||
                    (req_eff[3] && (cur_lvl <= LW'(3)));

  always_comb begin
    pend_n = pend;
    lat_n  = lat;
    if (wr_lat) lat_n = lat_n & ~bus_wdata[NLVL-1:0];
    lat_n = lat_n | req_eff;
    if (acc_fire) begin
      pend_n[acc_idx] = 1'b1;
      lat_n[acc_idx]  = 1'b0;
      if (acc_idx >= 4'(L_FIRST_MASKABLE)) pend_n[L_GDIS] = 1'b1;
    end
    if (ret_ok) begin
      if (!ret_addr_lsb) pend_n[ret_lvl] = 1'b0;
      if (ret_lvl == 4'd1 || ret_lvl >= 4'(L_FIRST_MASKABLE))
        pend_n[L_GDIS] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr        <= '0;
      mask       <= FIXED_BITS;
      pend       <= NLVL'(32'h12);
      lat        <= '0;
      prio       <= '0;
      acc_valid  <= 1'b0;
      acc_lvl    <= '0;
      acc_self   <= 1'b0;
      vec_sel    <= 1'b0;
      illegal_op <= 1'b0;
      dbl_fault  <= 1'b0;
    end else begin
      pend <= pend_n;
      lat  <= lat_n;
      if (wr_ovr)  ovr  <= bus_wdata;
      if (wr_mask) mask <= (bus_wdata[NLVL-1:0] & ~FIXED_BITS) | FIXED_BITS;
      if (wr_prio) prio <= bus_wdata[NLVL-1:0] & FIXED_BITS;
      acc_valid  <= acc_fire;
      acc_lvl    <= acc_fire ? acc_idx : '0;
      acc_self   <= acc_fire && ({1'b0, acc_idx} == cur_lvl);
      vec_sel    <= acc_fire && (acc_idx >= 4'(L_FIRST_GP)) && ovr[acc_idx];
      illegal_op <= ret_bad;
      dbl_fault  <= df_hit;
    end
  end

  always_comb begin
    case (bus_addr)
      A_OVR:   bus_rdata = ovr;
      A_MASK:  bus_rdata = DW'(mask);
      A_PEND:  bus_rdata = DW'(pend);
      A_LAT:   bus_rdata = DW'(lat);
      A_PRIO:  bus_rdata = DW'(prio);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [4:0]  bus_addr,
  input logic        ret_req,
  input logic        nest_en,
  input logic [15:0] pend,
  input logic        acc_fire,
  input logic [3:0]  acc_idx,
  input logic        ret_bad,
  input logic        acc_valid,
  input logic [3:0]  acc_lvl,
  input logic        super_mode,
  input logic [4:0]  cur_lvl
);
  AST_PEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h08 && !acc_fire && !ret_req) |=> $stable(pend)); // R2

  AST_SUPER_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    super_mode == (cur_lvl != 5'd16)); // R4

  AST_EQUAL_NEEDS_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_idx >= 4'd5 && {1'b0, acc_idx} == cur_lvl) |-> nest_en); // R7

  AST_ACCEPT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> pend[$past(acc_idx)]); // R8

  AST_ENTRY_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_lvl >= 4'd5) |-> pend[4]); // R9

  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |=> $stable(pend)); // R10

  AST_NO_ACCEPT_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> !acc_fire); // R12
endmodule

bind evt_ctrl evt_ctrl_chk u_chk (.*);

// File: tb/test_evt_ctrl.sv
module test_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_req = '0;
  logic        nest_en = 1'b0;
  logic        ret_req = 1'b0;
  logic [3:0]  ret_lvl = '0;
  logic        ret_addr_lsb = 1'b0;
  logic [4:0]  cur_lvl;
  logic        super_mode, acc_valid, acc_self, vec_sel, illegal_op, dbl_fault;
  logic [3:0]  acc_lvl;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit armed = 0, done = 0;

  // reference model state
  bit [15:0] m_pend, m_mask, m_lat, m_prio;
  bit [31:0] m_ovr;
  bit        e_acc, e_self, e_vec, e_ill, e_df;
  int        e_lvl;

  always #5 clk = ~clk;

  evt_ctrl i_evt_ctrl (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_ovr;
      5'h04: return {16'h0, m_mask};
      5'h08: return {16'h0, m_pend};
      5'h0C: return {16'h0, m_lat};
      5'h10: return {16'h0, m_prio};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int cur, win, rl;
    bit ok, legal, df;
    bit [15:0] req, cand, np, nl;
    cyc++;
    if (!rst_n) begin
      m_pend = 16'h0012; m_mask = 16'h001F; m_lat = '0; m_prio = '0; m_ovr = '0;
      e_acc = 0; e_self = 0; e_vec = 0; e_ill = 0; e_df = 0; e_lvl = 0;
      armed = 1;
    end else begin
      cur = 16;
      for (int i = 15; i >= 1; i--) if (i != 4 && m_pend[i]) cur = i;
      req = evt_req; req[4] = 1'b0;
      cand = m_lat | req;
      win = -1;
      if (!ret_req)
        for (int i = 0; i < 16; i++)
          if (win < 0 && cand[i]) begin
            if (i < 2) ok = 1;
            else if (i < 4) ok = (i < cur);
            else if (i == 4) ok = 0;
            else ok = m_mask[i] && (cur == 16 || !m_pend[4]) &&
                      (i < cur || (nest_en && i == cur));
            if (ok) win = i;
          end
      df = (req[2] && cur <= 2) || (req[3] && cur <= 3);
      rl = int'(ret_lvl);
      if (rl == 0) legal = m_pend[0];
      else if (cur == 16) legal = 0;
      else if (rl == 2 || rl == 3) legal = (cur == rl);
      else if (rl == 4) legal = 0;
      else legal = (cur != 2 && cur != 3);
      np = m_pend; nl = m_lat;
      if (bus_wr && bus_addr == 5'h0C) nl = nl & ~bus_wdata[15:0];
      nl = nl | req;
      if (win >= 0) begin
        np[win] = 1; nl[win] = 0;
        if (win >= 5) np[4] = 1;
      end
      if (ret_req && legal) begin
        if (!ret_addr_lsb) np[rl] = 0;
        if (rl == 1 || rl >= 5) np[4] = 0;
      end
      e_acc  = (win >= 0);
      e_lvl  = (win >= 0) ? win : 0;
      e_self = (win >= 0) && (win == cur);
      e_vec  = (win >= 7) && m_ovr[win];
      e_ill  = ret_req && !legal;
      e_df   = df;
      if (bus_wr && bus_addr == 5'h00) m_ovr = bus_wdata;
      if (bus_wr && bus_addr == 5'h04) m_mask = bus_wdata[15:0] | 16'h001F;
      if (bus_wr && bus_addr == 5'h10) m_prio = bus_wdata[15:0] & 16'h001F;
      m_pend = np; m_lat = nl;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    int mcur;
    if (rst_n && armed && !done) begin
      mcur = 16;
      for (int i = 15; i >= 1; i--) if (i != 4 && m_pend[i]) mcur = i;
      chk(32'(cur_lvl), 32'(mcur), "R4 model cur_lvl");
      chk(32'(super_mode), 32'(mcur != 16), "R4 model super_mode");
      chk(32'(acc_valid), 32'(e_acc), "R8 model acc_valid");
      chk(32'(acc_lvl), 32'(e_lvl), "R8 model acc_lvl");
      chk(32'(acc_self), 32'(e_self), "R9 model acc_self");
      chk(32'(vec_sel), 32'(e_vec), "R9 model vec_sel");
      chk(32'(illegal_op), 32'(e_ill), "R10 model illegal_op");
      chk(32'(dbl_fault), 32'(e_df), "R6 model dbl_fault");
      chk(bus_rdata, m_read(bus_addr), "R2 model rdata");
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(); bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    step(); bus_addr = a; #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic req(input logic [15:0] v);
    step(); evt_req = v;
    step(); evt_req = '0;
  endtask

  task automatic ret(input logic [3:0] l, input logic lsb);
    step(); ret_req = 1; ret_lvl = l; ret_addr_lsb = lsb;
    step(); ret_req = 0; ret_addr_lsb = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    // R1 reset state
    chk(32'(cur_lvl), 32'd1, "R1 reset cur_lvl");
    chk(32'(super_mode), 32'd1, "R1 reset super_mode");
    rd(5'h04, 32'h1F, "R1 reset mask");
    rd(5'h08, 32'h12, "R1 reset pend");
    rd(5'h0C, 32'h0, "R1 reset lat");
    rd(5'h00, 32'h0, "R1 reset ovr");
    // R2 register access
    wr(5'h04, 32'hFFFF_0000); rd(5'h04, 32'h1F, "R2 mask fixed bits");
    wr(5'h04, 32'h0000_FFA0); rd(5'h04, 32'hFFBF, "R2 mask maskable bits");
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, 32'h12, "R2 pend ignores write");
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, 32'h1F, "R2 prio keeps low bits");
    wr(5'h00, 32'hA5A5_0180); rd(5'h00, 32'hA5A5_0180, "R2 ovr full word");
    rd(5'h14, 32'h0, "R2 unused address");
    // R7 blocked by disable and mask, stays latched
    req(16'h0040);
    chk(32'(acc_valid), 32'd0, "R7 level 6 blocked");
    ret(4'd1, 1'b0);
    chk(32'(cur_lvl), 32'd16, "R11 return to user");
    step();
    chk(32'(acc_valid), 32'd0, "R7 mask bit clear blocks");
    rd(5'h0C, 32'h40, "R3 request latched");
    wr(5'h04, 32'h0000_FFFF);
    step();
    chk(32'(acc_valid), 32'd1, "R12 mask write re-arbitrates");
    chk(32'(acc_lvl), 32'd6, "R12 accepted level 6");
    rd(5'h08, 32'h50, "R9 entry sets disable");
    // R3 clear versus set
    req(16'h0200);
    rd(5'h0C, 32'h200, "R3 level 9 latched");
    step(); bus_wr = 1; bus_addr = 5'h0C; bus_wdata = 32'h300; evt_req = 16'h0110;
    step(); bus_wr = 0; evt_req = '0;
    rd(5'h0C, 32'h100, "R3 set wins, input 4 ignored");
    // R11/R12 return clears disable, latched 8 taken, vec_sel
    ret(4'd6, 1'b0);
    step();
    chk(32'(acc_lvl), 32'd8, "R12 latched level 8 taken");
    chk(32'(vec_sel), 32'd1, "R9 override selects vector");
    req(16'h0080);
    chk(32'(acc_valid), 32'd0, "R7 disable blocks level 7");
    ret(4'd8, 1'b1);
    step();
    chk(32'(acc_lvl), 32'd7, "R11 lsb keeps level 8, disable cleared");
    rd(5'h08, 32'h190, "R11 pend after nested entry");
    // R7 self nesting
    ret(4'd7, 1'b1);
    rd(5'h08, 32'h180, "R11 disable cleared, level kept");
    req(16'h0080);
    chk(32'(acc_valid), 32'd0, "R7 equal level without nesting");
    step(); nest_en = 1;
    step();
    chk(32'(acc_valid), 32'd1, "R7 equal level with nesting");
    chk(32'(acc_self), 32'd1, "R9 self flag");
    nest_en = 0;
    // R10 illegal returns
    ret(4'd3, 1'b0); chk(32'(illegal_op), 32'd1, "R10 level 3 return from 7");
    ret(4'd0, 1'b0); chk(32'(illegal_op), 32'd1, "R10 level 0 return without emulation");
    ret(4'd4, 1'b0); chk(32'(illegal_op), 32'd1, "R10 level 4 return");
    rd(5'h08, 32'h190, "R10 pend unchanged");
    // R6 level 2 and double fault
    req(16'h0004);
    chk(32'(acc_lvl), 32'd2, "R6 level 2 despite disable");
    req(16'h0008);
    chk(32'(dbl_fault), 32'd1, "R6 level 3 at level 2 faults");
    ret(4'd7, 1'b0); chk(32'(illegal_op), 32'd1, "R10 general return from level 2");
    ret(4'd2, 1'b0); chk(32'(illegal_op), 32'd0, "R10 level 2 return legal");
    step();
    chk(32'(acc_lvl), 32'd3, "R12 latched level 3 after return");
    // R5 levels 0 and 1, R8 one per edge
    req(16'h0001);
    chk(32'(acc_lvl), 32'd0, "R5 level 0 accepted");
    ret(4'd0, 1'b0); chk(32'(illegal_op), 32'd0, "R10 level 0 return legal");
    req(16'h0003);
    chk(32'(acc_lvl), 32'd0, "R8 lowest index first");
    step();
    chk(32'(acc_valid), 32'd1, "R5 level 1 next edge");
    chk(32'(acc_lvl), 32'd1, "R8 second acceptance");
    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule